// File: doc/BRIEF.md
# Stream-to-Memory DMA Receive Engine

This block is the receive side of a descriptor-driven DMA channel. A producer presents a beat of up to four bytes with a length and an end-of-packet flag. The engine stores the bytes into memory buffers that a chain of data descriptors describes. Each descriptor is four 32-bit words at consecutive byte offsets: +0 next descriptor address, +4 buffer start, +8 control flags, +12 buffer end (exclusive).

A descriptor closes when its buffer is full or when the packet ends. When it closes, the engine writes the control word back with the packet-end mark added. It overwrites the end word with the address where filling actually stopped, and it raises raw interrupt set requests. It then follows the next link, or it stops on an end-of-list descriptor after marking the channel context disabled in memory.

Software starts the engine by pulsing a start input with a descriptor address and a context address. Interrupt masking and register decode live in a separate register block. That block receives the raw set requests and returns the current raw value, so the engine can tell whether a set request really changes anything.

Top module: `dma_rx_engine`

## Requirements
- R1: While the channel end-of-list flag is set, or the engine is idle, `in_ready_o` is low and `in_taken_o` is zero for any offer.
- R2: On a handshake, the number of bytes taken equals the smaller of the offered length and the remaining space, where the remaining space is the buffer end minus the current pointer.
- R3: A descriptor closes when the pointer reaches the buffer end or when the accepted beat carries end-of-packet. The end word at descriptor offset +12 is then rewritten with the current pointer.
- R4: When a closing descriptor has its interrupt flag (control bit 4) set, raw interrupt bits 0 and 1 are requested together. Bit 2 is never requested.
- R5: When a descriptor closes on end-of-packet, control bit 11 is set in the written-back control word and raw interrupt bit 3 is requested.
- R6: `irq_update_o` pulses with a set request only when that request contains a bit not already present in `raw_intr_i`.
- R7: After write-back, a descriptor with control bit 0 (end of list) causes the following, and the engine then stops. The end-of-list flag is set. A single byte write sets bit 15 of the context word. The other bits of that word are preserved. Any other descriptor causes the engine to fetch the next descriptor and resume writing at that descriptor's buffer start.
- R8: `saved_buf_o` advances by the accepted byte count one clock edge after every accepted chunk.
- R9: Data writes use byte enables at the pointer's byte offset. A chunk that crosses a word boundary is written as two word writes. Memory bytes outside the accepted chunk are not changed.
- R10: `in_ready_o` is low while any memory access (descriptor fetch, data write or write-back) is in progress.
- R11: A start pulse in idle clears the end-of-list flag and fetches the descriptor at `desc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured in idle |
| desc_i | input | 32 | First descriptor address |
| ctx_i | input | 32 | Context word address |
| in_valid_i | input | 1 | Stream beat valid |
| in_ready_o | output | 1 | Engine can accept a beat |
| in_data_i | input | 32 | Beat bytes, byte 0 in bits 7:0 |
| in_len_i | input | 3 | Bytes offered (1 to 4) |
| in_eop_i | input | 1 | Beat ends the packet |
| in_taken_o | output | 3 | Bytes accepted this handshake |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_be_o | output | 4 | Write byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with ack |
| raw_intr_i | input | 4 | Current raw interrupt value |
| raw_set_o | output | 4 | Raw interrupt set request pulse |
| irq_update_o | output | 1 | Request changes the raw value |
| saved_buf_o | output | 32 | Current buffer write pointer |
| eol_o | output | 1 | Channel end-of-list flag |

## Verification
`in_taken_o` is combinational within the handshake cycle, so the bench reads it at the falling edge just before the accepting rising edge. `saved_buf_o` moves at that rising edge and is checked at the next falling edge. Data, control-word and end-word writes follow over later cycles, so their effects are checked only from the memory model after the engine reports end of list. Interrupt requests are logged at falling edges in the cycle they appear and are compared in order afterwards. This avoids counting cycles across memory waits.

// File: rtl/dma_rx_pkg.sv
package dma_rx_pkg;
  // control word bit positions inside a data descriptor
  localparam int F_EOL    = 0;
  localparam int F_INTR   = 4;
  localparam int F_IN_EOP = 11;
  // context word disable bit
  localparam int CTX_DIS  = 15;
  // raw interrupt bit positions
  localparam int IRQ_W    = 4;
  localparam int IRQ_DA   = 0;
  localparam int IRQ_DB   = 1;
  localparam int IRQ_EOP  = 3;
  localparam int DESC_WORDS = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_RECV, S_WR_LO, S_WR_HI,
    S_CLOSE, S_WB_FLAGS, S_WB_END, S_CTX
  } rx_state_e;
endpackage

// File: rtl/dma_rx_fill.sv
module dma_rx_fill #(
  parameter int AW   = 32,
  parameter int LENW = 3
) (
  input  logic [AW-1:0]   ptr_i,
  input  logic [AW-1:0]   end_i,
  input  logic [LENW-1:0] len_i,
  output logic [LENW-1:0] acc_o
);
  logic [AW-1:0] room;
  assign room  = end_i - ptr_i;
  assign acc_o = (room < AW'(len_i)) ? room[LENW-1:0] : len_i;
endmodule

// File: rtl/dma_rx_lane.sv
module dma_rx_lane #(
  parameter int DW   = 32,
  parameter int NB   = DW / 8,
  parameter int OFFW = $clog2(NB),
  parameter int LENW = $clog2(NB + 1)
) (
  input  logic [DW-1:0]   data_i,
  input  logic [OFFW-1:0] off_i,
  input  logic [LENW-1:0] cnt_i,
  output logic [2*DW-1:0] wdata_o,
  output logic [2*NB-1:0] be_o
);
  logic [NB-1:0] mask;
  for (genvar i = 0; i < NB; i++) begin : g_mask
    assign mask[i] = LENW'(i) < cnt_i;
  end
  assign wdata_o = {{DW{1'b0}}, data_i} << {off_i, 3'b000};
  assign be_o    = {{NB{1'b0}}, mask} << off_i;
endmodule

// File: rtl/dma_rx_irq.sv
module dma_rx_irq
  import dma_rx_pkg::*;
(
  input  logic             fire_i,
  input  logic             intr_i,
  input  logic             eop_i,
  input  logic [IRQ_W-1:0] raw_i,
  output logic [IRQ_W-1:0] set_o,
  output logic             upd_o
);
  always_comb begin
    set_o = '0;
    if (fire_i) begin
      set_o[IRQ_DA]  = intr_i;
      set_o[IRQ_DB]  = intr_i;
      set_o[IRQ_EOP] = eop_i;
    end
  end
  // only a request that changes the raw value re-evaluates the line
  assign upd_o = |(set_o & ~raw_i);
endmodule

// File: rtl/dma_rx_engine.sv
module dma_rx_engine
  import dma_rx_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int NB   = DW / 8,
  localparam int OFFW = $clog2(NB),
  localparam int LENW = $clog2(NB + 1),
  localparam int IXW  = $clog2(DESC_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    desc_i,
  input  logic [AW-1:0]    ctx_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [DW-1:0]    in_data_i,
  input  logic [LENW-1:0]  in_len_i,
  input  logic             in_eop_i,
  output logic [LENW-1:0]  in_taken_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [NB-1:0]    mem_be_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic [IRQ_W-1:0] raw_intr_i,
  output logic [IRQ_W-1:0] raw_set_o,
  output logic             irq_update_o,
  output logic [AW-1:0]    saved_buf_o,
  output logic             eol_o
);
  rx_state_e     state_q;
  logic [IXW-1:0] idx_q;
  logic [AW-1:0] desc_q, ctx_q, next_q, end_q, ptr_q, wbase_q;
  logic [DW-1:0] flags_q;
  logic          eol_q, eop_q;
  logic [2*DW-1:0] lat_data_q;
  logic [2*NB-1:0] lat_be_q;

  logic [LENW-1:0] acc;
  logic [2*DW-1:0] lane_data;
  logic [2*NB-1:0] lane_be;
  logic            hs, chunk_done;

  dma_rx_fill #(.AW(AW), .LENW(LENW)) u_fill (
    .ptr_i(ptr_q), .end_i(end_q), .len_i(in_len_i), .acc_o(acc)
  );

  dma_rx_lane #(.DW(DW)) u_lane (
    .data_i(in_data_i), .off_i(ptr_q[OFFW-1:0]), .cnt_i(acc),
    .wdata_o(lane_data), .be_o(lane_be)
  );

  dma_rx_irq u_irq (
    .fire_i(state_q == S_CLOSE), .intr_i(flags_q[F_INTR]), .eop_i(eop_q),
    .raw_i(raw_intr_i), .set_o(raw_set_o), .upd_o(irq_update_o)
  );

  assign in_ready_o  = (state_q == S_RECV) && !eol_q;
  assign hs          = in_valid_i && in_ready_o;
  assign in_taken_o  = hs ? acc : '0;
  assign saved_buf_o = ptr_q;
  assign eol_o       = eol_q;
  assign chunk_done  = (ptr_q == end_q) || eop_q;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_be_o    = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_q + AW'({idx_q, {OFFW{1'b0}}});
      end
      S_WR_LO: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = wbase_q;
        mem_be_o    = lat_be_q[NB-1:0];
        mem_wdata_o = lat_data_q[DW-1:0];
      end
      S_WR_HI: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = wbase_q + AW'(NB);
        mem_be_o    = lat_be_q[2*NB-1:NB];
        mem_wdata_o = lat_data_q[2*DW-1:DW];
      end
      S_WB_FLAGS: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_q + AW'(2 * NB);
        mem_be_o    = '1;
        mem_wdata_o = flags_q | (DW'(eop_q) << F_IN_EOP);
      end
      S_WB_END: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_q + AW'(3 * NB);
        mem_be_o    = '1;
        mem_wdata_o = DW'(ptr_q);
      end
      S_CTX: begin
        // single byte write: neighbouring context bits stay intact
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ctx_q;
        mem_be_o    = NB'(1) << (CTX_DIS / 8);
        mem_wdata_o = DW'(1) << CTX_DIS;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      idx_q      <= '0;
      desc_q     <= '0;
      ctx_q      <= '0;
      next_q     <= '0;
      end_q      <= '0;
      ptr_q      <= '0;
      wbase_q    <= '0;
      flags_q    <= '0;
      eol_q      <= 1'b0;
      eop_q      <= 1'b0;
      lat_data_q <= '0;
      lat_be_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          desc_q  <= desc_i;
          ctx_q   <= ctx_i;
          eol_q   <= 1'b0;
          idx_q   <= '0;
          state_q <= S_FETCH;
        end
        S_FETCH: if (mem_ack_i) begin
          unique case (idx_q)
            IXW'(0): next_q  <= AW'(mem_rdata_i);
            IXW'(1): ptr_q   <= AW'(mem_rdata_i);
            IXW'(2): flags_q <= mem_rdata_i;
            default: end_q   <= AW'(mem_rdata_i);
          endcase
          idx_q <= idx_q + 1'b1;
          if (idx_q == IXW'(DESC_WORDS - 1)) state_q <= S_RECV;
        end
        S_RECV: if (hs) begin
          ptr_q      <= ptr_q + AW'(acc);
          eop_q      <= in_eop_i;
          wbase_q    <= {ptr_q[AW-1:OFFW], {OFFW{1'b0}}};
          lat_data_q <= lane_data;
          lat_be_q   <= lane_be;
          state_q    <= (acc == '0) ? S_CLOSE : S_WR_LO;
        end
        S_WR_LO: if (mem_ack_i) begin
          if (lat_be_q[2*NB-1:NB] != '0) state_q <= S_WR_HI;
          else state_q <= chunk_done ? S_CLOSE : S_RECV;
        end
        S_WR_HI: if (mem_ack_i) state_q <= chunk_done ? S_CLOSE : S_RECV;
        S_CLOSE: state_q <= S_WB_FLAGS;
        S_WB_FLAGS: if (mem_ack_i) state_q <= S_WB_END;
        S_WB_END: if (mem_ack_i) begin
          eop_q <= 1'b0;
          if (flags_q[F_EOL]) begin
            state_q <= S_CTX;
          end else begin
            desc_q  <= next_q;
            idx_q   <= '0;
            state_q <= S_FETCH;
          end
        end
        S_CTX: if (mem_ack_i) begin
          eol_q   <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_rx_engine_chk.sv
module dma_rx_engine_chk
  import dma_rx_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [2:0]       in_len_i,
  input logic [2:0]       in_taken_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [3:0]       mem_be_o,
  input logic [IRQ_W-1:0] raw_intr_i,
  input logic [IRQ_W-1:0] raw_set_o,
  input logic             irq_update_o,
  input logic [31:0]      saved_buf_o,
  input logic             eol_o
);
  assert_refuse_at_eol_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |-> !in_ready_o && in_taken_o == '0);

  assert_take_bounded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_taken_o != '0) |-> in_valid_i && in_ready_o && in_taken_o <= in_len_i);

  assert_close_writes_back_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_set_o != '0) |=> mem_req_o && mem_we_o && mem_be_o == 4'hF);

  assert_desc_bits_paired_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_set_o[0] == raw_set_o[1] && !raw_set_o[2]);

  assert_update_needs_new_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_update_o |-> (raw_set_o & ~raw_intr_i) != '0);

  assert_no_update_on_same_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_set_o != '0 && (raw_set_o & ~raw_intr_i) == '0) |-> !irq_update_o);

  assert_ptr_advance_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_taken_o != '0) |=> saved_buf_o == $past(saved_buf_o) + 32'($past(in_taken_o)));

  assert_write_has_be_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_be_o != '0);

  assert_no_ready_in_access_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !mem_req_o);
endmodule

bind dma_rx_engine dma_rx_engine_chk chk_i (.*);

// File: tb/dma_rx_engine_tb_top.sv
`timescale 1ns/1ps
module dma_rx_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start, in_valid, in_ready, in_eop, mem_req, mem_we, irq_upd, eol;
  logic [31:0] desc, ctx, in_data, mem_addr, mem_wdata, mem_rdata, saved_buf;
  logic [2:0]  in_len, in_taken;
  logic [3:0]  mem_be, raw_q, raw_set;
  logic        raw_clr;
  logic [31:0] mem [0:255];

  int checks = 0, fails = 0, ev_n = 0;
  logic [3:0] ev_set [8];
  logic       ev_upd [8];
  bit         done = 0;

  dma_rx_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .desc_i(desc), .ctx_i(ctx),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_len_i(in_len), .in_eop_i(in_eop), .in_taken_o(in_taken),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_req),
    .mem_rdata_i(mem_rdata), .raw_intr_i(raw_q), .raw_set_o(raw_set),
    .irq_update_o(irq_upd), .saved_buf_o(saved_buf), .eol_o(eol)
  );

  function automatic logic [31:0] init_word(int i);
    case (i)
      64: return 32'h120;  65: return 32'h200; 66: return 32'h10;  67: return 32'h20A;
      72: return 32'h140;  73: return 32'h243; 74: return 32'h0;   75: return 32'h260;
      80: return 32'h0;    81: return 32'h280; 82: return 32'h11;  83: return 32'h284;
      88: return 32'h0;    89: return 32'h2A0; 90: return 32'h1;   91: return 32'h2A8;
      192: return 32'h000000C0;
      default: return 32'hEEEEEEEE;
    endcase
  endfunction

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
      raw_q <= '0;
    end else begin
      if (mem_req && mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      raw_q <= raw_clr ? 4'h0 : (raw_q | raw_set);
    end
  end

  always @(negedge clk) begin
    if (rst_n && raw_set != 0 && ev_n < 8) begin
      ev_set[ev_n] <= raw_set;
      ev_upd[ev_n] <= irq_upd;
      ev_n <= ev_n + 1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // data, len, eop, expected taken, expected pointer after the chunk
  localparam logic [70:0] VEC [6] = '{
    {32'h13121110, 3'd4, 1'b0, 3'd4, 32'h204},
    {32'h17161514, 3'd4, 1'b0, 3'd4, 32'h208},
    {32'h1B1A1918, 3'd4, 1'b0, 3'd2, 32'h20A},
    {32'h00001B1A, 3'd2, 1'b0, 3'd2, 32'h245},
    {32'h001E1D1C, 3'd3, 1'b1, 3'd3, 32'h248},
    {32'h23222120, 3'd4, 1'b0, 3'd4, 32'h284}
  };

  task automatic offer(logic [31:0] d, logic [2:0] l, logic e, output logic [2:0] tk,
                       output logic [31:0] pt);
    int guard = 0;
    in_valid = 1; in_data = d; in_len = l; in_eop = e;
    #1;
    while (!in_ready && guard < 200) begin @(negedge clk); #1; guard++; end
    tk = in_taken;
    @(posedge clk); @(negedge clk);
    pt = saved_buf;
    in_valid = 0;
  endtask

  task automatic wait_eol();
    int guard = 0;
    while (!eol && guard < 500) begin @(negedge clk); guard++; end
  endtask

  task automatic do_start(logic [31:0] d);
    @(negedge clk);
    start = 1; desc = d; ctx = 32'h300;
    @(negedge clk);
    start = 0;
  endtask

  initial begin
    logic [2:0] tk; logic [31:0] pt;
    start = 0; desc = 0; ctx = 0; in_valid = 0; in_data = 0; in_len = 0; in_eop = 0;
    raw_clr = 0;
    repeat (3) @(negedge clk);
    check("R1 reset ready", {31'b0, in_ready}, 0);
    check("R1 reset eol", {31'b0, eol}, 0);
    check("R10 reset req", {31'b0, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle ready", {31'b0, in_ready}, 0);
    do_start(32'h100);
    check("R10 ready low in fetch", {31'b0, in_ready}, 0);
    check("R10 fetch req", {31'b0, mem_req}, 1);
    for (int k = 0; k < 6; k++) begin
      offer(VEC[k][70:39], VEC[k][38:36], VEC[k][35], tk, pt);
      check($sformatf("R2 taken vec%0d", k), {29'b0, tk}, {29'b0, VEC[k][34:32]});
      check($sformatf("R8 pointer vec%0d", k), pt, VEC[k][31:0]);
    end
    wait_eol();
    check("R7 eol set", {31'b0, eol}, 1);
    // offers after end of list must be refused
    in_valid = 1; in_data = 32'h99; in_len = 3'd4; in_eop = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check("R1 refused at eol", {28'b0, in_ready, in_taken}, 0);
    end
    in_valid = 0;
    check("R9 d0 word0", mem[128], 32'h13121110);
    check("R9 d0 word1", mem[129], 32'h17161514);
    check("R9 d0 partial tail", mem[130], 32'hEEEE1918);
    check("R3 d0 end rewritten", mem[67], 32'h20A);
    check("R4 d0 flags kept", mem[66], 32'h10);
    check("R9 d1 unaligned head", mem[144], 32'h1AEEEEEE);
    check("R9 d1 crossing word", mem[145], 32'h1E1D1C1B);
    check("R9 d1 beyond untouched", mem[146], 32'hEEEEEEEE);
    check("R5 d1 in-eop bit", mem[74], 32'h800);
    check("R3 d1 end at eop", mem[75], 32'h248);
    check("R7 d2 data", mem[160], 32'h23222120);
    check("R3 d2 end", mem[83], 32'h284);
    check("R7 ctx disabled", mem[192], 32'h000080C0);
    check("R4 event count", ev_n, 3);
    check("R4 d0 set", {28'b0, ev_set[0]}, 32'h3);
    check("R6 d0 update", {31'b0, ev_upd[0]}, 1);
    check("R5 d1 set", {28'b0, ev_set[1]}, 32'h8);
    check("R6 d1 update", {31'b0, ev_upd[1]}, 1);
    check("R4 d2 set", {28'b0, ev_set[2]}, 32'h3);
    check("R6 d2 no update", {31'b0, ev_upd[2]}, 0);
    // restart on a fresh list: eop on a one-byte chunk
    @(negedge clk); raw_clr = 1; @(negedge clk); raw_clr = 0;
    do_start(32'h160);
    check("R11 eol cleared", {31'b0, eol}, 0);
    offer(32'h00000055, 3'd1, 1'b1, tk, pt);
    check("R2 single byte", {29'b0, tk}, 1);
    check("R8 single byte ptr", pt, 32'h2A1);
    wait_eol();
    check("R7 eol again", {31'b0, eol}, 1);
    check("R9 single byte write", mem[168], 32'hEEEEEE55);
    check("R5 d3 flags", mem[90], 32'h801);
    check("R3 d3 end", mem[91], 32'h2A1);
    check("R6 d3 update", {31'b0, ev_upd[3]}, 1);
    check("R5 d3 set", {28'b0, ev_set[3]}, 32'h8);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule